// File: doc/BRIEF.md
# Minimum Inter-Packet Idle Tracker

This block watches a stream of decoded symbol pairs, each marked as idle or not, and measures how many idle pairs make up every gap between packets. It keeps the smallest gap seen since it was last cleared, saturated at 7, together with the number of times that smallest gap has occurred. Both values are presented in one 16-bit read word using compact non-binary codes. An event pulse tells the surrounding logic that the minimum has dropped or that the occurrence count has advanced. Reading the word clears it.

A small state machine follows the stream. It has three states. `ST_PRE` is the reset state, where no packet has been seen yet. `ST_PKT` means a non-idle pair was seen last. `ST_GAP` means idle pairs are being counted. The transitions are as follows:
- `ST_PRE`→`ST_PKT` on the first non-idle pair.
- `ST_PKT`→`ST_GAP` on an idle pair, which loads the count with 1.
- `ST_GAP`→`ST_GAP` on a further idle pair, which adds one to the count, saturating at 7.
- `ST_GAP`→`ST_PKT` on a non-idle pair, which closes the gap.

Idle pairs in `ST_PRE` and non-idle pairs in `ST_PKT` leave the state where it is.

The closed gap is compared with the stored minimum. The compare updates the minimum and the occurrence count, and it produces the event.

Top module: `idle_gap_min_tracker`

## Requirements
- R1: After synchronous reset the read word is 16'h0040: minimum 7, occurrence 1. The event output is low.
- R2: Bits 15 to 7 of the read word are always zero.
- R3: Bits 6:4 carry the minimum, coded 7→100, 6→101, 5→111, 4→110, 3→010, 2→011, 1→001, 0→000. Every gap has at least one pair, so the value 0 is never reached.
- R4: Bits 3:0 carry the occurrence count, coded 1→0000, 2→1000, 3→1100, 4→0100, 5→0101, 6→0111, 7→1111, 8→1110, 9→1010, 10→0010, 11→0011, 12→0001, 13→1001, 14→1101, 15→0110, 16→1011.
- R5: A gap closes on the first valid non-idle pair that follows one or more valid idle pairs, after a packet has been seen. Its length saturates at 7. Idle pairs before the first non-idle pair after reset are ignored, and so are cycles with the valid strobe low.
- R6: A closed gap shorter than the stored minimum becomes the new minimum and sets the occurrence count to 1. The event output pulses high for one cycle, in the cycle after the closing pair.
- R7: A closed gap equal to the minimum increments the occurrence count. With the mode input high, every increment pulses the event. With the mode input low, only the increment that reaches 16 pulses the event.
- R8: The occurrence count stays at 16. A further equal gap changes nothing and raises no event.
- R9: A closed gap longer than the minimum changes neither field and raises no event.
- R10: The read word is valid in the cycle the read strobe is high. From the next cycle the fields are back at 7 and 1. A gap that closes in the read cycle is discarded. Gap tracking carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pair_valid | input | 1 | A decoded symbol pair is present this cycle |
| pair_is_idle | input | 1 | The present pair is an idle pair |
| rd_stb | input | 1 | Read strobe; clears the fields after this cycle |
| evt_every | input | 1 | 1: event on every increment; 0: event only on reaching 16 |
| rd_word | output | 16 | Read word: minimum code in 6:4, occurrence code in 3:0 |
| evt_pulse | output | 1 | One-cycle event pulse |

## Verification
The hardest state to reach is the saturated occurrence count. It needs sixteen gaps of exactly equal length with no shorter gap and no read in between. A further equal gap must then show that the count neither wraps nor raises an event. The bench drives dedicated sweeps of identical gaps, in both event modes, from a cleared state. It also runs a long pseudo-random stream with reads that sometimes land on the closing pair, checked against an arithmetic model every cycle.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

    localparam int GAP_W   = 3;
    localparam int OCC_W   = 5;
    localparam int MIN_W   = 3;
    localparam int CODE_W  = 4;
    localparam int GAP_MAX = (1 << GAP_W) - 1;
    localparam int OCC_MAX = 1 << (CODE_W);

    typedef enum logic [1:0] {
        ST_PRE = 2'd0,
        ST_PKT = 2'd1,
        ST_GAP = 2'd2
    } gap_state_e;

    function automatic logic [MIN_W-1:0] min_code(input logic [GAP_W-1:0] v);
        logic [MIN_W-1:0] c;
        unique case (v)
            3'd7: c = 3'b100;
            3'd6: c = 3'b101;
            3'd5: c = 3'b111;
            3'd4: c = 3'b110;
            3'd3: c = 3'b010;
            3'd2: c = 3'b011;
            3'd1: c = 3'b001;
            default: c = 3'b000;
        endcase
        return c;
    endfunction

    function automatic logic [CODE_W-1:0] occ_code(input logic [OCC_W-1:0] n);
        logic [CODE_W-1:0] c;
        unique case (n)
            5'd2:  c = 4'b1000;
            5'd3:  c = 4'b1100;
            5'd4:  c = 4'b0100;
            5'd5:  c = 4'b0101;
            5'd6:  c = 4'b0111;
            5'd7:  c = 4'b1111;
            5'd8:  c = 4'b1110;
            5'd9:  c = 4'b1010;
            5'd10: c = 4'b0010;
            5'd11: c = 4'b0011;
            5'd12: c = 4'b0001;
            5'd13: c = 4'b1001;
            5'd14: c = 4'b1101;
            5'd15: c = 4'b0110;
            5'd16: c = 4'b1011;
            default: c = 4'b0000;
        endcase
        return c;
    endfunction

    function automatic logic [GAP_W-1:0] min_decode(input logic [MIN_W-1:0] c);
        logic [GAP_W-1:0] v;
        v = '0;
        for (int k = 0; k <= GAP_MAX; k++) begin
            if (min_code(GAP_W'(k)) == c) v = GAP_W'(k);
        end
        return v;
    endfunction

endpackage

// File: rtl/idle_gap_fsm.sv
module idle_gap_fsm
    import idle_gap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_valid,
    input  logic             pair_is_idle,
    output logic             gap_close,
    output logic [GAP_W-1:0] gap_len
);

    gap_state_e       state_q, state_d;
    logic [GAP_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pair_valid) begin
            unique case (state_q)
                ST_PRE: begin
                    if (!pair_is_idle) state_d = ST_PKT;
                end
                ST_PKT: begin
                    if (pair_is_idle) begin
                        state_d = ST_GAP;
                        cnt_d   = GAP_W'(1);
                    end
                end
                ST_GAP: begin
                    if (pair_is_idle) begin
                        if (cnt_q != GAP_W'(GAP_MAX)) cnt_d = cnt_q + GAP_W'(1);
                    end else begin
                        state_d = ST_PKT;
                    end
                end
                default: state_d = ST_PRE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        gap_close = pair_valid && !pair_is_idle && (state_q == ST_GAP);
        gap_len   = cnt_q;
    end

endmodule

// File: rtl/idle_gap_min_store.sv
module idle_gap_min_store
    import idle_gap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             gap_close,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             evt_every,
    output logic [GAP_W-1:0] min_val,
    output logic [OCC_W-1:0] occ_val,
    output logic             evt
);

    logic [GAP_W-1:0] min_d;
    logic [OCC_W-1:0] occ_d;
    logic             evt_d;
    logic             is_lower, is_equal, can_inc;

    always_comb begin
        is_lower = gap_len < min_val;
        is_equal = gap_len == min_val;
        can_inc  = occ_val != OCC_W'(OCC_MAX);
        min_d    = min_val;
        occ_d    = occ_val;
        evt_d    = 1'b0;
        if (clr) begin
            min_d = GAP_W'(GAP_MAX);
            occ_d = OCC_W'(1);
        end else if (gap_close) begin
            if (is_lower) begin
                min_d = gap_len;
                occ_d = OCC_W'(1);
                evt_d = 1'b1;
            end else if (is_equal && can_inc) begin
                occ_d = occ_val + OCC_W'(1);
                evt_d = evt_every || (occ_d == OCC_W'(OCC_MAX));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            min_val <= GAP_W'(GAP_MAX);
            occ_val <= OCC_W'(1);
            evt     <= 1'b0;
        end else begin
            min_val <= min_d;
            occ_val <= occ_d;
            evt     <= evt_d;
        end
    end

endmodule

// File: rtl/idle_gap_min_tracker.sv
module idle_gap_min_tracker
    import idle_gap_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int MIN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_valid,
    input  logic              pair_is_idle,
    input  logic              rd_stb,
    input  logic              evt_every,
    output logic [WORD_W-1:0] rd_word,
    output logic              evt_pulse
);

    localparam int USED_W = MIN_LSB + MIN_W;

    logic             gap_close;
    logic [GAP_W-1:0] gap_len;
    logic [GAP_W-1:0] min_val;
    logic [OCC_W-1:0] occ_val;

    idle_gap_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .pair_valid   (pair_valid),
        .pair_is_idle (pair_is_idle),
        .gap_close    (gap_close),
        .gap_len      (gap_len)
    );

    idle_gap_min_store store_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (rd_stb),
        .gap_close (gap_close),
        .gap_len   (gap_len),
        .evt_every (evt_every),
        .min_val   (min_val),
        .occ_val   (occ_val),
        .evt       (evt_pulse)
    );

    always_comb begin
        rd_word                          = '0;
        rd_word[USED_W-1:MIN_LSB]        = min_code(min_val);
        rd_word[CODE_W-1:0]              = occ_code(occ_val);
    end

endmodule

// File: rtl/idle_gap_min_tracker_chk.sv
module idle_gap_min_tracker_chk
    import idle_gap_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        pair_valid,
    input logic        pair_is_idle,
    input logic        rd_stb,
    input logic [15:0] rd_word,
    input logic        evt_pulse
);

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_word == 16'h0040);

    assert_evt_after_close_R6: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |-> $past(pair_valid && !pair_is_idle && !rd_stb));

    assert_evt_spaced_R5: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |=> !evt_pulse);

    assert_min_not_rising_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> min_decode(rd_word[6:4]) <= $past(min_decode(rd_word[6:4])));

    assert_occ_held_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_word[3:0] == 4'b1011 && !rd_stb) |=>
        (rd_word[3:0] == 4'b1011 || rd_word[6:4] != $past(rd_word[6:4])));

endmodule

bind idle_gap_min_tracker idle_gap_min_tracker_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .pair_valid   (pair_valid),
    .pair_is_idle (pair_is_idle),
    .rd_stb       (rd_stb),
    .rd_word      (rd_word),
    .evt_pulse    (evt_pulse)
);

// File: tb/idle_gap_min_tracker_tb_top.sv
module idle_gap_min_tracker_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pair_valid = 1'b0;
    logic        pair_is_idle = 1'b0;
    logic        rd_stb = 1'b0;
    logic        evt_every = 1'b0;
    logic [15:0] rd_word;
    logic        evt_pulse;

    int checks = 0;
    int errors = 0;

    int m_state = 0;
    int m_cnt   = 0;
    int m_min   = 7;
    int m_occ   = 1;
    bit m_evt   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_gap_min_tracker dut_i (
        .clk          (clk),
        .rst          (rst),
        .pair_valid   (pair_valid),
        .pair_is_idle (pair_is_idle),
        .rd_stb       (rd_stb),
        .evt_every    (evt_every),
        .rd_word      (rd_word),
        .evt_pulse    (evt_pulse)
    );

    function automatic logic [2:0] exp_min(input int v);
        case (v)
            7: return 3'b100; 6: return 3'b101; 5: return 3'b111; 4: return 3'b110;
            3: return 3'b010; 2: return 3'b011; 1: return 3'b001; default: return 3'b000;
        endcase
    endfunction

    function automatic logic [3:0] exp_occ(input int n);
        case (n)
            1: return 4'b0000;  2: return 4'b1000;  3: return 4'b1100;  4: return 4'b0100;
            5: return 4'b0101;  6: return 4'b0111;  7: return 4'b1111;  8: return 4'b1110;
            9: return 4'b1010; 10: return 4'b0010; 11: return 4'b0011; 12: return 4'b0001;
            13: return 4'b1001; 14: return 4'b1101; 15: return 4'b0110; default: return 4'b1011;
        endcase
    endfunction

    function automatic logic [15:0] exp_word();
        return {9'b0, exp_min(m_min), exp_occ(m_occ)};
    endfunction

    task automatic check_word(input string tag);
        checks++;
        if (rd_word !== exp_word()) begin
            errors++;
            $display("FAIL %s: rd_word actual %h expected %h", tag, rd_word, exp_word());
        end
    endtask

    task automatic check_evt(input string tag);
        checks++;
        if (evt_pulse !== m_evt) begin
            errors++;
            $display("FAIL %s: evt_pulse actual %b expected %b", tag, evt_pulse, m_evt);
        end
    endtask

    // One clock: drive at the negedge, check the word before the edge, update the model, check after.
    task automatic cyc(input bit v, input bit idle, input bit rd, input string tag);
        bit close;
        int g;
        pair_valid   = v;
        pair_is_idle = idle;
        rd_stb       = rd;
        #1;
        check_word(rd ? "R10" : tag);
        @(posedge clk);
        close = v && !idle && (m_state == 2);
        g     = (m_cnt > 7) ? 7 : m_cnt;
        m_evt = 1'b0;
        if (rd) begin
            m_min = 7;
            m_occ = 1;
        end else if (close) begin
            if (g < m_min) begin
                m_min = g; m_occ = 1; m_evt = 1'b1;
            end else if (g == m_min && m_occ < 16) begin
                m_occ++;
                m_evt = evt_every || (m_occ == 16);
            end
        end
        if (v) begin
            if (idle) begin
                if (m_state == 1) begin m_state = 2; m_cnt = 1; end
                else if (m_state == 2) m_cnt = (m_cnt >= 7) ? 7 : m_cnt + 1;
            end else begin
                m_state = 1;
            end
        end
        @(negedge clk);
        pair_valid = 1'b0; rd_stb = 1'b0;
        check_evt(tag);
        check_word(tag);
    endtask

    task automatic gap(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b1, 1'b0, tag);
        cyc(1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic do_read();
        cyc(1'b0, 1'b0, 1'b1, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 and R2: reset word
        checks++;
        if (rd_word !== 16'h0040 || evt_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: word/evt actual %h/%b expected 0040/0", rd_word, evt_pulse);
        end
        @(negedge clk);

        // R5: leading idles before any packet are ignored
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b0, "R5");
        cyc(1'b1, 1'b0, 1'b0, "R5");
        // R5: valid-low cycles inside a gap are not counted
        cyc(1'b1, 1'b1, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, "R5");
        cyc(1'b0, 1'b0, 1'b0, "R5");
        cyc(1'b1, 1'b1, 1'b0, "R5");
        cyc(1'b1, 1'b0, 1'b0, "R5");
        do_read();

        // R3 and R6: descending gap lengths walk the minimum codes; long gap saturates (R5)
        for (int g = 9; g >= 1; g--) gap(g, "R3");
        // R9: larger gaps change nothing
        for (int g = 2; g <= 8; g++) gap(g, "R9");
        do_read();

        // R4, R7, R8: equal gaps in both event modes
        for (int mode = 0; mode < 2; mode++) begin
            evt_every = mode[0];
            gap(3, "R6");
            for (int k = 0; k < 18; k++) gap(3, mode ? "R7" : "R4");
            gap(3, "R8");
            gap(4, "R9");
            gap(7, "R9");
            do_read();
            // saturated gap length equals the reset minimum (R7)
            gap(9, "R7");
            gap(7, "R7");
            do_read();
        end

        // R10: read in the same cycle as a closing pair discards that gap
        gap(5, "R10");
        cyc(1'b1, 1'b1, 1'b0, "R10");
        cyc(1'b1, 1'b1, 1'b0, "R10");
        cyc(1'b1, 1'b0, 1'b1, "R10");
        gap(2, "R10");

        // Pseudo-random sweep against the model
        for (int k = 0; k < 6000; k++) begin
            bit v, i, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = lfsr[0] | lfsr[1];
            i = lfsr[2] | (lfsr[3] & lfsr[4]);
            r = (lfsr[8:5] == 4'hF);
            if (lfsr[11:9] == 3'b000) evt_every = lfsr[12];
            cyc(v, i, r, "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule